// File: doc/BRIEF.md
# Three-Wire Serial Register Slave with Burst Read

This block is the serial front end of a register-mapped peripheral. A host controls it with an active-low select, a serial clock and a single data line. The host drives that data line for commands, and the block drives it back for read data. Every transaction opens with a command byte. Its top bit selects the direction and its lower seven bits hold a register address. A write then carries one data byte inward, which the block presents on a simple register-file write port. A read returns one byte taken from the register-file read port.

One command address opens a burst. The block then streams a fixed run of consecutive registers without any further addressing. It stays on the last register of the run for as long as the host keeps clocking, and it ignores everything else until select is released. A write of a fixed key to a fixed address raises a one-cycle soft-reset pulse. The surrounding register file uses that pulse to restore its defaults.

The block runs on a fast system clock. The serial clock, select and data inputs each pass through a two-stage synchronizer, and serial clock edges are found by comparing successive synchronized samples. The data line is modelled as an output value plus an output enable, which the pad ring combines into a tri-state pin.

Top module: `tw_reg_slave`

## Requirements
- R1: A command byte is received MSB first. Its bit 7 equal to 1 marks a write, and bits 6..0 are the register address. For a write, the following byte (MSB first) is the data: after its eighth bit the block raises `wr_en` for exactly one clock, with `wr_addr` and `wr_data` holding the address and the data.
- R2: Serial input bits are taken at rising serial clock edges. A bit placed on the line while the serial clock is low is the bit captured.
- R3: While `sel_n` is high, serial clock and data activity has no effect (no write occurs), and `sdio_oe` is 0.
- R4: Raising `sel_n` before a write's data byte is complete aborts it: no write takes place. The first byte after the next selection is decoded as a command byte.
- R5: For a read (bit 7 equal to 0, address not the burst address), the addressed register's byte is returned MSB first. Each bit is launched on a falling serial clock edge and held until the next falling edge. `sdio_oe` is 1 through the whole data byte and returns to 0 at the falling edge that follows its last bit. `sdio_oe` is 0 while a command byte is received.
- R6: A read of address 0x63 starts a burst that returns registers 0x03, 0x04, 0x05, 0x06, 0x07, 0x08 and 0x09 in that order, one byte each, without further command bytes.
- R7: Once a burst has returned register 0x09, further bytes clocked in the same burst keep returning register 0x09.
- R8: During a burst, bytes sent by the host are not decoded. A write pattern causes no write, and a second burst command does not restart the sequence. Only raising `sel_n` ends the burst.
- R9: A write of data 0x5a to address 0x3a raises `soft_rst` for one clock, in the same cycle as its `wr_en`. A write of any other data to 0x3a leaves `soft_rst` at 0.
- R10: Commands may follow each other back to back under one selection, with no release of `sel_n` between them.
- R11: While `rst_n` is low and after it is released, `sdio_oe`, `wr_en` and `soft_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host, idle high |
| sdio_i | input | 1 | Data line value as seen at the pad input |
| sdio_o | output | 1 | Data line value to drive during reads |
| sdio_oe | output | 1 | Output enable for the data line pad |
| rd_addr | output | 7 | Register-file read address |
| rd_data | input | 8 | Register-file read data for `rd_addr` |
| wr_en | output | 1 | One-cycle register-file write strobe |
| wr_addr | output | 7 | Register-file write address |
| wr_data | output | 8 | Register-file write data |
| soft_rst | output | 1 | One-cycle request to restore register defaults |

## Verification
The bench builds the block with its default parameters: a seven-bit address, the burst command at 0x63, a seven-entry burst starting at 0x03, and the reset key 0x5a at 0x3a. With a seven-entry run, the saturation on the last entry shows after eight bytes. The bench clocks nine bytes and then continues with write and burst patterns to check that the port stays locked. A serial half-period of eight system clocks lets each launched bit settle through the synchronizers well before the host samples it. The same spacing gives the block time to fetch the next burst byte between a byte's last rising edge and the next falling edge.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_WDATA = 2'd1,
    ST_RDATA = 2'd2,
    ST_BURST = 2'd3
  } tw_state_e;

endpackage

// File: rtl/tw_sync2.sv
module tw_sync2 #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic stage1_q;
      logic stage2_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage1_q <= RST_VAL[g];
          stage2_q <= RST_VAL[g];
        end else begin
          stage1_q <= d[g];
          stage2_q <= stage1_q;
        end
      end

      assign q[g] = stage2_q;
    end
  endgenerate

endmodule

// File: rtl/tw_tx_shift.sv
module tw_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_o
);

  logic [W-1:0] buf_q, buf_d;
  logic         out_q, out_d;

  always_comb begin
    buf_d = buf_q;
    out_d = out_q;
    if (load) begin
      buf_d = load_val;
    end else if (shift) begin
      out_d = buf_q[W-1];
      buf_d = {buf_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      out_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      out_q <= out_d;
    end
  end

  assign bit_o = out_q;

endmodule

// File: rtl/tw_burst_idx.sv
module tw_burst_idx #(
  parameter int                  ADDR_W = 7,
  parameter int                  LEN    = 7,
  parameter logic [ADDR_W-1:0]   BASE   = 7'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [IDX_W-1:0]  LAST      = IDX_W'(LEN - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE + ADDR_W'(LEN - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (start) begin
      idx_d = '0;
    end else if (adv && (idx_q != LAST)) begin
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign addr_o = BASE + ADDR_W'(idx_q);

  AST_BURST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o >= BASE) && (addr_o <= LAST_ADDR)); // R6

  AST_BURST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && addr_o == LAST_ADDR) |=> (addr_o == LAST_ADDR)); // R7

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int                 ADDR_W     = 7,
  parameter int                 DATA_W     = 8,
  parameter logic [ADDR_W-1:0]  BURST_CMD  = 7'h63,
  parameter logic [ADDR_W-1:0]  BURST_BASE = 7'h03,
  parameter int                 BURST_LEN  = 7,
  parameter logic [ADDR_W-1:0]  RST_REG    = 7'h3a,
  parameter logic [DATA_W-1:0]  RST_KEY    = 8'h5a
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              soft_rst
);
  import tw_pkg::*;

  localparam int FRAME_W = ADDR_W + 1;
  localparam int SH_W    = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int CNT_W   = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  // synchronized serial inputs
  logic sel_s, sclk_s, sdio_s;
  tw_sync2 #(.W(3), .RST_VAL(3'b110)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_n, sclk, sdio_i}),
    .q     ({sel_s, sclk_s, sdio_s})
  );

  logic sclk_d_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d_q <= 1'b1;
    else        sclk_d_q <= sclk_s;
  end

  logic sclk_rise, sclk_fall;
  assign sclk_rise = sclk_s & ~sclk_d_q & ~sel_s;
  assign sclk_fall = ~sclk_s & sclk_d_q & ~sel_s;

  // state
  tw_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   shr_q, shr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_q, load_d;
  logic              oe_q, oe_d;
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [DATA_W-1:0] wr_data_q, wr_data_d;
  logic              srst_q, srst_d;
  logic              burst_start, burst_adv, tx_shift;
  logic [SH_W-1:0]   shifted_in;
  logic [ADDR_W-1:0] burst_addr;

  assign shifted_in = {shr_q[SH_W-2:0], sdio_s};

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    shr_d       = shr_q;
    addr_d      = addr_q;
    load_d      = 1'b0;
    oe_d        = oe_q;
    wr_en_d     = 1'b0;
    wr_addr_d   = wr_addr_q;
    wr_data_d   = wr_data_q;
    srst_d      = 1'b0;
    burst_start = 1'b0;
    burst_adv   = 1'b0;
    tx_shift    = 1'b0;

    if (sel_s) begin
      st_d  = ST_CMD;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      if (sclk_fall) begin
        if (st_q == ST_RDATA || st_q == ST_BURST) begin
          oe_d     = 1'b1;
          tx_shift = 1'b1;
        end else begin
          oe_d = 1'b0;
        end
      end

      if (sclk_rise) begin
        shr_d = shifted_in;
        cnt_d = cnt_q + CNT_W'(1);
        unique case (st_q)
          ST_CMD: begin
            if (cnt_q == CMD_LAST) begin
              cnt_d  = '0;
              addr_d = shifted_in[ADDR_W-1:0];
              if (shifted_in[FRAME_W-1]) begin
                st_d = ST_WDATA;
              end else if (shifted_in[ADDR_W-1:0] == BURST_CMD) begin
                st_d        = ST_BURST;
                burst_start = 1'b1;
                load_d      = 1'b1;
              end else begin
                st_d   = ST_RDATA;
                load_d = 1'b1;
              end
            end
          end
          ST_WDATA: begin
            if (cnt_q == DATA_LAST) begin
              cnt_d     = '0;
              st_d      = ST_CMD;
              wr_en_d   = 1'b1;
              wr_addr_d = addr_q;
              wr_data_d = shifted_in[DATA_W-1:0];
              srst_d    = (addr_q == RST_REG) &&
                          (shifted_in[DATA_W-1:0] == RST_KEY);
            end
          end
          ST_RDATA: begin
            if (cnt_q == DATA_LAST) begin
              cnt_d = '0;
              st_d  = ST_CMD;
            end
          end
          ST_BURST: begin
            if (cnt_q == DATA_LAST) begin
              cnt_d     = '0;
              burst_adv = 1'b1;
              load_d    = 1'b1;
            end
          end
          default: st_d = ST_CMD;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_CMD;
      cnt_q     <= '0;
      shr_q     <= '0;
      addr_q    <= '0;
      load_q    <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      srst_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      shr_q     <= shr_d;
      addr_q    <= addr_d;
      load_q    <= load_d;
      oe_q      <= oe_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      srst_q    <= srst_d;
    end
  end

  tw_burst_idx #(.ADDR_W(ADDR_W), .LEN(BURST_LEN), .BASE(BURST_BASE)) i_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (burst_start),
    .adv    (burst_adv),
    .addr_o (burst_addr)
  );

  tw_tx_shift #(.W(DATA_W)) i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_q),
    .load_val (rd_data),
    .shift    (tx_shift),
    .bit_o    (sdio_o)
  );

  assign rd_addr  = (st_q == ST_BURST) ? burst_addr : addr_q;
  assign sdio_oe  = oe_q;
  assign wr_en    = wr_en_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;
  assign soft_rst = srst_q;

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !sdio_oe); // R3

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R1

  AST_NO_WRITE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BURST) |=> !wr_en); // R8

  AST_SRST_WITH_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (wr_en && wr_addr == RST_REG && wr_data == RST_KEY)); // R9

  AST_OE_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WDATA) |-> !sdio_oe); // R5

endmodule

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;

  localparam int HALF = 8;

  logic       clk;
  logic       rst_n;
  logic       sel_n;
  logic       sclk;
  logic       sdio_i;
  logic       sdio_o;
  logic       sdio_oe;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic       soft_rst;

  tw_reg_slave i_tw_reg_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .sclk     (sclk),
    .sdio_i   (sdio_i),
    .sdio_o   (sdio_o),
    .sdio_oe  (sdio_oe),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .soft_rst (soft_rst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // register-file environment
  logic [7:0] mem [128];
  function automatic logic [7:0] dflt(input logic [6:0] a);
    return {1'b0, a} ^ 8'hc3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= dflt(7'(i));
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end
  assign rd_data = mem[rd_addr];

  // scoreboard
  typedef struct { logic [6:0] a; logic [7:0] d; string tag; } wr_item_t;
  typedef struct { logic [7:0] d; string tag; } rd_item_t;
  wr_item_t   exp_wr[$];
  rd_item_t   exp_rd[$];
  logic [7:0] act_rd[$];
  int checks = 0;
  int errors = 0;
  int srst_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_wr.size() == 0) begin
        chk(0, "R3 or R4 or R8 unexpected write", {17'd0, wr_addr, wr_data}, 32'h0);
      end else begin
        wr_item_t it;
        it = exp_wr.pop_front();
        chk({wr_addr, wr_data} == {it.a, it.d}, it.tag, {17'd0, wr_addr, wr_data}, {17'd0, it.a, it.d});
      end
    end
    if (rst_n && soft_rst) srst_seen++;
    if (act_rd.size() > 0 && exp_rd.size() > 0) begin
      rd_item_t e;
      logic [7:0] a;
      e = exp_rd.pop_front();
      a = act_rd.pop_front();
      chk(a == e.d, e.tag, {24'd0, a}, {24'd0, e.d});
    end
  end

  // host driver
  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] r,
                           output logic any_oe, output logic all_oe);
    any_oe = 1'b0;
    all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sclk   = 1'b0;
      sdio_i = b[i];
      repeat (HALF) @(negedge clk);
      r[i]   = sdio_o;
      any_oe = any_oe | sdio_oe;
      all_oe = all_oe & sdio_oe;
      sclk   = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic select_on();
    @(negedge clk);
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic select_off();
    @(negedge clk);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string tag);
    logic [7:0] r;
    logic ao, lo;
    wr_item_t it;
    it.a = a; it.d = d; it.tag = tag;
    exp_wr.push_back(it);
    xfer_byte({1'b1, a}, r, ao, lo);
    chk(ao == 1'b0, "R5 line released during command byte", {31'd0, ao}, 32'd0);
    xfer_byte(d, r, ao, lo);
    chk(ao == 1'b0, "R5 line not driven during write data", {31'd0, ao}, 32'd0);
  endtask

  task automatic read_byte(input logic [7:0] expd, input string tag);
    logic [7:0] r;
    logic ao, lo;
    rd_item_t it;
    it.d = expd; it.tag = tag;
    exp_rd.push_back(it);
    xfer_byte(8'h00, r, ao, lo);
    chk(lo == 1'b1, "R5 line driven through data byte", {31'd0, lo}, 32'd1);
    act_rd.push_back(r);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] expd, input string tag);
    logic [7:0] r;
    logic ao, lo;
    xfer_byte({1'b0, a}, r, ao, lo);
    chk(ao == 1'b0, "R5 line released during command byte", {31'd0, ao}, 32'd0);
    read_byte(expd, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic ao, lo;
    rst_n  = 1'b0;
    sel_n  = 1'b1;
    sclk   = 1'b1;
    sdio_i = 1'b0;
    repeat (5) @(negedge clk);
    chk({sdio_oe, wr_en, soft_rst} == 3'b000, "R11 outputs in reset", {29'd0, sdio_oe, wr_en, soft_rst}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({sdio_oe, wr_en, soft_rst} == 3'b000, "R11 outputs after reset", {29'd0, sdio_oe, wr_en, soft_rst}, 0);

    // R1 R2 basic write then read
    select_on();
    do_write(7'h10, 8'ha5, "R1 R2 write 0x10");
    select_off();
    select_on();
    do_read(7'h10, 8'ha5, "R5 R2 read back 0x10");
    select_off();
    select_on();
    do_read(7'h11, dflt(7'h11), "R5 read default 0x11");
    select_off();

    // R10 back to back under one select
    select_on();
    do_write(7'h20, 8'h3c, "R10 write 0x20");
    do_read(7'h20, 8'h3c, "R10 read 0x20");
    do_write(7'h21, 8'h99, "R10 write 0x21 after read");
    do_read(7'h21, 8'h99, "R10 read 0x21");
    select_off();

    // R3 traffic while deselected
    xfer_byte(8'h85, r, ao, lo);
    chk(ao == 1'b0, "R3 line idle while deselected", {31'd0, ao}, 0);
    xfer_byte(8'h77, r, ao, lo);
    chk(ao == 1'b0, "R3 line idle while deselected", {31'd0, ao}, 0);
    select_on();
    do_read(7'h05, dflt(7'h05), "R3 register 0x05 untouched");
    select_off();

    // R4 abort mid write
    select_on();
    xfer_byte(8'hb0, r, ao, lo);
    for (int i = 7; i >= 4; i--) begin
      @(negedge clk); sclk = 1'b0; sdio_i = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    select_off();
    select_on();
    do_read(7'h30, dflt(7'h30), "R4 aborted write left 0x30 and next byte is a command");
    select_off();

    // R6 R7 burst
    select_on();
    for (int i = 0; i < 7; i++) do_write(7'(3 + i), 8'(8'h90 + i), "R6 preload burst register");
    select_off();
    select_on();
    xfer_byte(8'h63, r, ao, lo);
    for (int i = 0; i < 7; i++) read_byte(8'(8'h90 + i), "R6 burst order");
    read_byte(8'h96, "R7 burst holds last register");
    read_byte(8'h96, "R7 burst holds last register again");
    // R8 locked port
    begin
      rd_item_t it;
      it.d = 8'h96; it.tag = "R8 write pattern ignored in burst";
      exp_rd.push_back(it);
      xfer_byte(8'h83, r, ao, lo);
      act_rd.push_back(r);
      it.tag = "R8 data pattern ignored in burst";
      exp_rd.push_back(it);
      xfer_byte(8'h55, r, ao, lo);
      act_rd.push_back(r);
      it.tag = "R8 second burst command ignored";
      exp_rd.push_back(it);
      xfer_byte(8'h63, r, ao, lo);
      act_rd.push_back(r);
    end
    select_off();
    select_on();
    do_read(7'h03, 8'h90, "R8 register 0x03 unchanged after locked burst");
    select_off();

    // R9 soft reset key
    select_on();
    do_write(7'h3a, 8'h11, "R9 non-key write to reset address");
    select_off();
    chk(srst_seen == 0, "R9 no reset on other data", srst_seen, 0);
    select_on();
    do_write(7'h3a, 8'h5a, "R9 key write");
    select_off();
    chk(srst_seen == 1, "R9 one reset pulse on key", srst_seen, 1);
    select_on();
    do_read(7'h10, dflt(7'h10), "R9 defaults restored");
    select_off();

    repeat (20) @(negedge clk);
    chk(exp_wr.size() == 0, "R1 all expected writes seen", exp_wr.size(), 0);
    chk(exp_rd.size() == 0 && act_rd.size() == 0, "R5 all reads compared",
        exp_rd.size() + act_rd.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule